// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eleven maskable interrupt sources for a small 8-bit processor core and turns them into one request line plus a 16-bit service address. Eight sources are on-chip peripherals that deliver one-cycle set pulses. The other three are external pins. Each pin passes through a synchronizer and a trigger unit that can be set to falling edge, rising edge, both edges or low level.

Every source has a pending flag and an enable bit. Software reaches both through a small register window with combinational read-back. A global master enable gates the request to the core. When the core acknowledges, the block latches the address of the highest-priority pending, enabled source and drops the master enable, so nesting is blocked until return-from-interrupt. Software clears peripheral flags itself. Edge-triggered pin flags clear themselves on acknowledge. A separate wake output leaves stop mode whenever an enabled flag is pending, whatever the state of the master enable.

Priority index p runs from 0 (highest) to 10: key scan, interval timer, pin 0, pin 1, timer 0, timer 1, pin 2, remote receiver, A/D done, serial port, watch timer.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every flag, enable and trigger field is 0, `master_en` is 0, `irq_req` and `wake` are 0, and `vec_addr` is FFFEh.
- R2: A pulse on `periph_set[k]` sets a flag, with k = 0..7 mapping to key scan, interval timer, timer 0, timer 1, remote, A/D, serial, watch timer. In the high request register, bit 6 down to bit 0 hold p = 0..6. In the low request register, bit 6 down to bit 3 hold p = 7..10, and bit 7 of both registers reads 0.
- R3: `irq_req` is 1 exactly when `master_en` is 1 and at least one flag is both pending and enabled. `wake` follows the pending-and-enabled condition alone, regardless of `master_en`.
- R4: On a cycle where `irq_ack` and `irq_req` are both 1, `vec_addr` takes FFFCh − 2·p for the lowest pending, enabled p, visible from the next cycle. At all other times `vec_addr` holds its value.
- R5: A taken acknowledge clears `master_en`, and it wins over every command in the same cycle. Otherwise `cmd_di` clears it, and it wins over `cmd_ei` and `cmd_reti`, either of which sets it.
- R6: Writing a 0 to a request bit clears that flag, and writing a 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R7: Trigger field codes are 00 = falling, 01 = rising, 10 = both edges and 11 = low level. Pin e uses bits 2e+1:2e of the trigger register. An edge flag is set by the selected transition, seen after a two-flop synchronizer.
- R8: In level mode the pin's flag equals the inverted synchronized pin. Acknowledges and software writes do not change it.
- R9: A taken acknowledge clears the winning flag only when that source is a pin in an edge mode. Peripheral flags stay set.
- R10: When several flags are pending together, the ones that lose arbitration stay pending and are vectored in priority order after each return-from-interrupt.
- R11: Register addresses are 0 = high request, 1 = low request, 2 = high enable, 3 = low enable (same bit layout as the request registers) and 4 = trigger select (bits 5:0). Writes take effect at the clock edge where `reg_we` is 1, and `reg_rdata` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_set | input | 8 | One-cycle set pulses from on-chip peripherals |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmd_ei | input | 1 | Set master enable |
| cmd_di | input | 1 | Clear master enable |
| cmd_reti | input | 1 | Return-from-interrupt, restores master enable |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | Latched service address |
| master_en | output | 1 | Master enable flag |
| wake | output | 1 | Stop-mode release |

## Verification
Two collisions can land on the same clock edge. The first is a peripheral set pulse and a software write of 0 to the same request bit. The bench drives both in one cycle and then expects the flag read back as 1. The second is an acknowledge and a return-from-interrupt in one cycle. The bench expects `master_en` to end at 0, and the scoreboard also expects the latched address of the winning level-mode pin.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int N_SRC    = 11;
   localparam int N_EXT    = 3;
   localparam int N_PERIPH = N_SRC - N_EXT;
   localparam int IDX_W    = $clog2(N_SRC);

   localparam logic [N_SRC-1:0] MASK_HI  = 11'b000_0111_1111;
   localparam logic [N_SRC-1:0] MASK_LO  = 11'b111_1000_0000;
   localparam logic [N_SRC-1:0] EXT_MASK = 11'b000_0100_1100;

   typedef enum logic [1:0] {
      TRIG_FALL  = 2'b00,
      TRIG_RISE  = 2'b01,
      TRIG_BOTH  = 2'b10,
      TRIG_LEVEL = 2'b11
   } trig_mode_e;

   typedef enum logic [2:0] {
      A_REQ_HI = 3'd0,
      A_REQ_LO = 3'd1,
      A_EN_HI  = 3'd2,
      A_EN_LO  = 3'd3,
      A_TRIG   = 3'd4
   } reg_addr_e;

   // priority slot of each external pin
   function automatic int ext_slot(input int e);
      case (e)
         0:       return 2;
         1:       return 3;
         default: return 6;
      endcase
   endfunction

   // priority slot of each peripheral set input
   function automatic int periph_slot(input int k);
      case (k)
         0:       return 0;
         1:       return 1;
         2:       return 4;
         3:       return 5;
         4:       return 7;
         5:       return 8;
         6:       return 9;
         default: return 10;
      endcase
   endfunction

   function automatic logic [7:0] pack_hi(input logic [N_SRC-1:0] v);
      logic [7:0] r;
      r = '0;
      for (int i = 0; i < 7; i++) r[6-i] = v[i];
      return r;
   endfunction

   function automatic logic [7:0] pack_lo(input logic [N_SRC-1:0] v);
      logic [7:0] r;
      r = '0;
      for (int i = 7; i < N_SRC; i++) r[13-i] = v[i];
      return r;
   endfunction

   function automatic logic [N_SRC-1:0] unpack_hi(input logic [7:0] b);
      logic [N_SRC-1:0] r;
      r = '0;
      for (int i = 0; i < 7; i++) r[i] = b[6-i];
      return r;
   endfunction

   function automatic logic [N_SRC-1:0] unpack_lo(input logic [7:0] b);
      logic [N_SRC-1:0] r;
      r = '0;
      for (int i = 7; i < N_SRC; i++) r[i] = b[13-i];
      return r;
   endfunction

endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect
   import irq_prio_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  trig_mode_e mode_i,
   output logic       hit_o,
   output logic       level_act_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              synced;

   assign synced = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= synced;
      end
   end

   always_comb begin
      case (mode_i)
         TRIG_FALL: hit_o = prev_q & ~synced;
         TRIG_RISE: hit_o = ~prev_q & synced;
         TRIG_BOTH: hit_o = prev_q ^ synced;
         default:   hit_o = 1'b0;
      endcase
   end

   assign level_act_o = ~synced;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] lvl_sel_i,
   input  logic [N-1:0] lvl_val_i,
   output logic [N-1:0] flag_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            q <= 1'b0;
         else if (lvl_sel_i[i]) q <= lvl_val_i[i];
         else if (set_i[i])     q <= 1'b1;
         else if (clr_i[i])     q <= 1'b0;
      end
      assign flag_o[i] = q;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 11,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     active_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (active_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |active_i;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] VEC_TOP     = 16'hFFFC,
   parameter logic [15:0] VEC_RESET   = 16'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PERIPH-1:0] periph_set,
   input  logic [N_EXT-1:0]  ext_pin,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   input  logic              cmd_reti,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              master_en,
   output logic              wake
);

   localparam int TRIG_W = 2 * N_EXT;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < IDX_W + 2 || ADDR_W > 16) begin : g_chk_addr
      $error("ADDR_W out of range");
   end

   logic [N_SRC-1:0]  pend, en_q, active;
   logic [N_SRC-1:0]  set_v, swclr_v, ackclr_v, lvl_sel, lvl_val;
   logic [TRIG_W-1:0] trig_q;
   logic [N_EXT-1:0]  ext_hit, ext_lvl;
   logic              any_act, take;
   logic [IDX_W-1:0]  win_idx;
   logic              wr_req_hi, wr_req_lo, wr_en_hi, wr_en_lo, wr_trig;
   logic              unused_wbit;

   assign unused_wbit = reg_wdata[7];

   // register write decode
   assign wr_req_hi = reg_we && (reg_addr == A_REQ_HI);
   assign wr_req_lo = reg_we && (reg_addr == A_REQ_LO);
   assign wr_en_hi  = reg_we && (reg_addr == A_EN_HI);
   assign wr_en_lo  = reg_we && (reg_addr == A_EN_LO);
   assign wr_trig   = reg_we && (reg_addr == A_TRIG);

   // external pin front ends
   for (genvar e = 0; e < N_EXT; e++) begin : g_ext
      irq_ext_detect #(.STAGES(SYNC_STAGES)) u_det (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_i      (ext_pin[e]),
         .mode_i     (trig_mode_e'(trig_q[2*e +: 2])),
         .hit_o      (ext_hit[e]),
         .level_act_o(ext_lvl[e])
      );
   end

   // route events into priority slots
   always_comb begin
      set_v   = '0;
      lvl_sel = '0;
      lvl_val = '0;
      for (int k = 0; k < N_PERIPH; k++) set_v[periph_slot(k)] = periph_set[k];
      for (int e = 0; e < N_EXT; e++) begin
         set_v[ext_slot(e)]   = ext_hit[e];
         lvl_sel[ext_slot(e)] = (trig_q[2*e +: 2] == TRIG_LEVEL);
         lvl_val[ext_slot(e)] = ext_lvl[e];
      end
   end

   always_comb begin
      swclr_v = '0;
      if (wr_req_hi) swclr_v = MASK_HI & ~unpack_hi(reg_wdata);
      if (wr_req_lo) swclr_v = MASK_LO & ~unpack_lo(reg_wdata);
   end

   assign active  = pend & en_q;
   assign irq_req = master_en & any_act;
   assign wake    = any_act;
   assign take    = irq_ack & irq_req;

   irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
      .active_i(active),
      .any_o   (any_act),
      .idx_o   (win_idx)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_ackclr
      if (EXT_MASK[i]) begin : g_ext_slot
         assign ackclr_v[i] = take && (win_idx == IDX_W'(i)) && !lvl_sel[i];
      end else begin : g_int_slot
         assign ackclr_v[i] = 1'b0;
      end
   end

   irq_flag_bank #(.N(N_SRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_v),
      .clr_i    (swclr_v | ackclr_v),
      .lvl_sel_i(lvl_sel),
      .lvl_val_i(lvl_val),
      .flag_o   (pend)
   );

   // enables and trigger select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         trig_q <= '0;
      end else begin
         if (wr_en_hi) en_q <= (en_q & ~MASK_HI) | unpack_hi(reg_wdata);
         if (wr_en_lo) en_q <= (en_q & ~MASK_LO) | unpack_lo(reg_wdata);
         if (wr_trig)  trig_q <= reg_wdata[TRIG_W-1:0];
      end
   end

   // master enable: acknowledge, then disable, then enable/return
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 master_en <= 1'b0;
      else if (take)              master_en <= 1'b0;
      else if (cmd_di)            master_en <= 1'b0;
      else if (cmd_ei || cmd_reti) master_en <= 1'b1;
   end

   // vector latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    vec_addr <= VEC_RESET[ADDR_W-1:0];
      else if (take) vec_addr <= VEC_TOP[ADDR_W-1:0]
                                 - {{(ADDR_W-IDX_W-1){1'b0}}, win_idx, 1'b0};
   end

   // read mux
   always_comb begin
      case (reg_addr)
         A_REQ_HI: reg_rdata = pack_hi(pend);
         A_REQ_LO: reg_rdata = pack_lo(pend);
         A_EN_HI:  reg_rdata = pack_hi(en_q);
         A_EN_LO:  reg_rdata = pack_lo(en_q);
         A_TRIG:   reg_rdata = {{(8-TRIG_W){1'b0}}, trig_q};
         default:  reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int          ADDR_W  = 16,
   parameter logic [15:0] VEC_TOP = 16'hFFFC,
   parameter int          N_SRC   = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ei,
   input logic              cmd_di,
   input logic              cmd_reti,
   input logic              irq_ack,
   input logic              irq_req,
   input logic [ADDR_W-1:0] vec_addr,
   input logic              master_en,
   input logic              wake
);

   localparam logic [ADDR_W-1:0] VEC_LOW = VEC_TOP[ADDR_W-1:0] - ADDR_W'(2 * (N_SRC - 1));

   p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (master_en && wake));

   p_ack_drops_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !master_en);

   p_di_drops_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_di |=> !master_en);

   p_ei_sets_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_ei || cmd_reti) && !cmd_di && !(irq_ack && irq_req)) |=> master_en);

   p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_ack && irq_req) |=> $stable(vec_addr));

   p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> (!vec_addr[0] && vec_addr >= VEC_LOW
                                && vec_addr <= VEC_TOP[ADDR_W-1:0]));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .VEC_TOP(VEC_TOP),
   .N_SRC  (irq_prio_pkg::N_SRC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_ei   (cmd_ei),
   .cmd_di   (cmd_di),
   .cmd_reti (cmd_reti),
   .irq_ack  (irq_ack),
   .irq_req  (irq_req),
   .vec_addr (vec_addr),
   .master_en(master_en),
   .wake     (wake)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  periph_set = '0;
   logic [2:0]  ext_pin = 3'b111;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        cmd_ei = 1'b0, cmd_di = 1'b0, cmd_reti = 1'b0, irq_ack = 1'b0;
   logic        irq_req, master_en, wake;
   logic [15:0] vec_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic ack_seen = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_prio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .periph_set(periph_set), .ext_pin(ext_pin),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
      .cmd_reti(cmd_reti), .irq_ack(irq_ack), .irq_req(irq_req),
      .vec_addr(vec_addr), .master_en(master_en), .wake(wake)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      cyc(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      reg_addr = a;
      #1;
      chk(req, {24'h0, reg_rdata}, {24'h0, exp});
   endtask

   task automatic pset(input logic [7:0] v);
      periph_set = v;
      cyc(1);
      periph_set = '0;
   endtask

   task automatic ei();   cmd_ei = 1'b1;   cyc(1); cmd_ei = 1'b0;   endtask
   task automatic di();   cmd_di = 1'b1;   cyc(1); cmd_di = 1'b0;   endtask
   task automatic reti(); cmd_reti = 1'b1; cyc(1); cmd_reti = 1'b0; endtask

   // driver: push the expected vector, then pulse acknowledge
   task automatic ack(input logic [15:0] exp, input string req);
      exp_q.push_back(exp);
      tag_q.push_back(req);
      irq_ack = 1'b1;
      cyc(1);
      irq_ack = 1'b0;
   endtask

   // monitor: compare the latched vector one cycle after each acknowledge
   always @(posedge clk) ack_seen <= irq_ack;
   always @(negedge clk) begin
      if (ack_seen) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4 actual=%0h expected=none", vec_addr);
         end else begin
            chk(tag_q.pop_front(), {16'h0, vec_addr}, {16'h0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 irq_req", irq_req, 0);
      chk("R1 master_en", master_en, 0);
      chk("R1 wake", wake, 0);
      chk("R1 vec_addr", vec_addr, 16'hFFFE);
      rd(3'd0, 8'h00, "R1 req_hi");
      rd(3'd1, 8'h00, "R1 req_lo");
      rd(3'd2, 8'h00, "R1 en_hi");
      rd(3'd3, 8'h00, "R1 en_lo");
      rd(3'd4, 8'h00, "R1 trig");

      // R2 flag layout: key scan, timer 1, watch timer
      pset(8'b1000_1001);
      rd(3'd0, 8'h42, "R2 req_hi layout");
      rd(3'd1, 8'h08, "R2 req_lo layout");

      // R3 gating
      chk("R3 wake no enable", wake, 0);
      wr(3'd2, 8'h02);
      rd(3'd2, 8'h02, "R11 en_hi readback");
      chk("R3 wake ignores master", wake, 1);
      chk("R3 req needs master", irq_req, 0);
      ei();
      chk("R5 ei sets master", master_en, 1);
      chk("R3 req with master", irq_req, 1);

      // R4 / R9 / R10: serve in priority order
      wr(3'd2, 8'h7F);
      wr(3'd3, 8'h78);
      rd(3'd3, 8'h78, "R11 en_lo readback");
      ack(16'hFFFC, "R4 key scan vector");
      chk("R5 ack clears master", master_en, 0);
      chk("R3 req off after ack", irq_req, 0);
      rd(3'd0, 8'h42, "R9 internal flag kept");
      wr(3'd0, 8'h3F);
      rd(3'd0, 8'h02, "R6 write0 clears, write1 keeps");
      reti();
      chk("R5 reti sets master", master_en, 1);
      ack(16'hFFF2, "R10 timer1 after reti");
      wr(3'd0, 8'h7D);
      reti();
      ack(16'hFFE8, "R10 watch timer last");
      wr(3'd1, 8'h70);
      rd(3'd1, 8'h00, "R6 lo cleared");
      reti();
      chk("R4 no request left", irq_req, 0);

      // R6 set and clear collide
      periph_set = 8'b0010_0000;
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h00;
      cyc(1);
      periph_set = '0; reg_we = 1'b0;
      rd(3'd1, 8'h20, "R6 set wins over clear");
      wr(3'd1, 8'h00);
      rd(3'd1, 8'h00, "R6 later clear");
      wr(3'd0, 8'hFF);
      rd(3'd0, 8'h00, "R6 write1 no set");

      // R7 falling edge on pin 0
      ext_pin[0] = 1'b0;
      cyc(4);
      rd(3'd0, 8'h10, "R7 falling edge pin0");
      ack(16'hFFF8, "R4 pin0 vector");
      rd(3'd0, 8'h00, "R9 edge flag cleared by ack");
      reti();
      // R7 rising edge on pin 1
      wr(3'd4, 8'h04);
      rd(3'd4, 8'h04, "R11 trig readback");
      ext_pin[1] = 1'b0;
      cyc(4);
      rd(3'd0, 8'h00, "R7 rising ignores fall");
      ext_pin[1] = 1'b1;
      cyc(4);
      rd(3'd0, 8'h08, "R7 rising edge pin1");
      wr(3'd0, 8'h77);
      // R7 both edges on pin 2
      wr(3'd4, 8'h24);
      ext_pin[2] = 1'b0;
      cyc(4);
      rd(3'd0, 8'h01, "R7 both edges fall");
      wr(3'd0, 8'h7E);
      ext_pin[2] = 1'b1;
      cyc(4);
      rd(3'd0, 8'h01, "R7 both edges rise");
      wr(3'd0, 8'h7E);
      rd(3'd0, 8'h00, "R6 pin2 cleared");

      // R8 level mode on pin 0 (pin already low)
      wr(3'd4, 8'h27);
      cyc(3);
      rd(3'd0, 8'h10, "R8 level follows pin");
      ack(16'hFFF8, "R4 level vector");
      rd(3'd0, 8'h10, "R8 ack leaves level flag");
      wr(3'd0, 8'h00);
      rd(3'd0, 8'h10, "R8 write leaves level flag");
      ext_pin[0] = 1'b1;
      cyc(4);
      rd(3'd0, 8'h00, "R8 level released");
      reti();

      // R5 ack and reti in one cycle
      ext_pin[0] = 1'b0;
      cyc(4);
      chk("R3 level request", irq_req, 1);
      exp_q.push_back(16'hFFF8);
      tag_q.push_back("R4 vector on ack+reti");
      irq_ack = 1'b1; cmd_reti = 1'b1;
      cyc(1);
      irq_ack = 1'b0; cmd_reti = 1'b0;
      chk("R5 ack beats reti", master_en, 0);
      ext_pin[0] = 1'b1;
      cyc(4);
      ei();
      di();
      chk("R5 di clears", master_en, 0);
      cmd_ei = 1'b1; cmd_di = 1'b1;
      cyc(1);
      cmd_ei = 1'b0; cmd_di = 1'b0;
      chk("R5 di beats ei", master_en, 0);
      wr(3'd4, 8'h24);
      ei();

      // R10 simultaneous arrivals: timer 0 and serial
      pset(8'b0100_0100);
      ack(16'hFFF4, "R10 timer0 wins");
      wr(3'd0, 8'h7B);
      rd(3'd1, 8'h10, "R10 serial still pending");
      reti();
      chk("R10 request after reti", irq_req, 1);
      ack(16'hFFEA, "R10 serial vector");
      cyc(2);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule